// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel words. A strobe at sixteen times the bit rate paces it, and each pulse is one tick. While idle, the receiver watches the synchronized line for a high-to-low transition. That transition restarts its tick counter at the first tick of the bit. The line is sampled three times near the middle of each bit, and the bit value is decided by a two-of-three vote. Data bits are collected least-significant first in a private shift register. An optional parity bit and one stop bit follow the data.

The receive path has two stages. When the stop bit has been sampled, the shifter contents move into a holding register that the host can read, and the ready flag rises. The noise, parity and framing results for the frame are gathered as its bits arrive. They become visible only in that same transfer cycle. A one-cycle read strobe clears the ready flag and every error flag. If a frame completes while older data is still unread, the older data is kept and the overrun flag is set. The format inputs select 8 or 9 data bits, turn parity on or off, and choose odd or even parity.

Top module: `sci_rx_core`

## Requirements
- R1: While `rx_en` is 0, the receiver neither searches for a start bit nor assembles a frame. A frame in progress when `rx_en` falls is discarded, and the holding register and flags keep their values.
- R2: While idle, a 1 followed by a 0 on the synchronized line, both seen at ticks, starts a bit at tick 1. If the vote at ticks 8 to 10 of that bit gives 1, the receiver returns to the search state and produces no frame.
- R3: Each bit is sampled at ticks 8, 9 and 10 of its bit time, and its value is the majority of the three samples.
- R4: If the three samples of any bit in a frame (start, data, parity or stop) disagree, the noise flag is set for that frame. The received data is still the majority value.
- R5: When `nine_bit` is 0, the frame carries 8 data bits, first bit into `rx_data[0]`, with `rx_data[8]` = 0. When `nine_bit` is 1, it carries 9 data bits into `rx_data[8:0]`, first bit into bit 0.
- R6: When `par_en` is 1, one parity bit follows the data. With `par_odd` = 0, the XOR of the data and parity bits must be 0. With `par_odd` = 1, it must be 1. A mismatch sets the parity flag. When `par_en` is 0, the parity flag stays 0.
- R7: A stop bit whose vote is 0 sets the framing flag. The frame is still transferred.
- R8: In the cycle of the transfer after the stop bit, the holding register loads the frame and `rdy` rises, both in the same cycle.
- R9: The noise, parity and framing flags change only when a frame is transferred or the register is read. During a frame, including its stop bit before the transfer, they keep their previous values.
- R10: A one-cycle `rd` pulse clears `rdy`, the noise, parity and framing flags, and `overrun`.
- R11: A frame that completes while `rdy` is 1 and no read occurs in that cycle sets `overrun`. The holding register and the other flags keep the older frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd | input | 1 | Host read strobe: consumes the held frame |
| rx_data | output | DATA_MAX (9) | Held received word |
| rdy | output | 1 | Held word is unread |
| noise_flag | output | 1 | Sample disagreement seen in the held frame |
| parity_flag | output | 1 | Parity mismatch in the held frame |
| frame_flag | output | 1 | Stop bit of the held frame was 0 |
| overrun | output | 1 | A frame was lost because the held word was unread |

## Verification
A scoreboard predicts each frame's word and flags, including frames with a one-tick glitch placed exactly at the second sample. A design that skipped the vote or sampled at the wrong tick would return a corrupted word or miss the noise flag. A short low pulse tests the start confirmation: a design that trusted the bare edge would deliver a spurious frame. A peek inside the stop bit of a bad-parity frame catches flags that appear before the transfer. Overrun, disable in the middle of a frame, and read-clear are each checked at the ports. A design that overwrote unread data or kept a half-built frame after disable would show the wrong word.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;

  typedef enum logic {
    BP_SEARCH = 1'b0,
    BP_ACTIVE = 1'b1
  } bp_state_e;

  typedef struct packed {
    logic noise;
    logic parity;
    logic frame;
  } rx_err_t;

endpackage

// File: rtl/sci_rx_sync.sv
module sci_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sci_rx_bitproc.sv
module sci_rx_bitproc
  import sci_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SMP_FIRST = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic rxd,
  input  logic halt,
  output logic bit_vld,
  output logic bit_val,
  output logic bit_noise
);

  localparam int CW = $clog2(OVS + 1);
  localparam logic [CW-1:0] T_ONE  = CW'(1);
  localparam logic [CW-1:0] T_LAST = CW'(OVS);
  localparam logic [CW-1:0] T_S0   = CW'(SMP_FIRST);
  localparam logic [CW-1:0] T_S1   = CW'(SMP_FIRST + 1);
  localparam logic [CW-1:0] T_S2   = CW'(SMP_FIRST + 2);

  bp_state_e     state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          prev;
  logic [1:0]    smp;
  logic          vote;
  logic          split;

  assign cnt_nxt = (cnt == T_LAST) ? T_ONE : cnt + T_ONE;
  assign vote    = (smp[0] & smp[1]) | (smp[0] & rxd) | (smp[1] & rxd);
  assign split   = ~((smp[0] == smp[1]) && (smp[1] == rxd));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= BP_SEARCH;
      cnt       <= '0;
      prev      <= 1'b0;
      smp       <= '0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      bit_noise <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (tick) prev <= rxd;
      if (halt) begin
        state <= BP_SEARCH;
        cnt   <= '0;
      end else if (tick) begin
        case (state)
          BP_SEARCH: begin
            if (prev && !rxd) begin
              state <= BP_ACTIVE;
              cnt   <= T_ONE;
            end
          end
          BP_ACTIVE: begin
            cnt <= cnt_nxt;
            if (cnt_nxt == T_S0) smp[0] <= rxd;
            if (cnt_nxt == T_S1) smp[1] <= rxd;
            if (cnt_nxt == T_S2) begin
              bit_vld   <= 1'b1;
              bit_val   <= vote;
              bit_noise <= split;
            end
          end
          default: state <= BP_SEARCH;
        endcase
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == BP_ACTIVE) |-> (cnt >= T_ONE && cnt <= T_LAST)) else $error("tick counter out of range"); // R2

  AST_VLD_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(tick)) else $error("bit decided without a tick"); // R3

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bit_vld && state == BP_SEARCH)) else $error("bit processor active while disabled"); // R1

endmodule

// File: rtl/sci_rx_frame.sv
module sci_rx_frame
  import sci_rx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                nine_bit,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                bit_vld,
  input  logic                bit_val,
  input  logic                bit_noise,
  output logic                halt,
  output logic                xfer,
  output logic [DATA_MAX-1:0] xdata,
  output rx_err_t             xerr
);

  localparam int IW = $clog2(DATA_MAX + 4);
  localparam logic [IW-1:0] I_ONE   = IW'(1);
  localparam logic [IW-1:0] N_LONG  = IW'(DATA_MAX);
  localparam logic [IW-1:0] N_SHORT = IW'(DATA_MAX - 1);

  logic [IW-1:0]       idx;
  logic [IW-1:0]       ndata;
  logic [IW-1:0]       stop_idx;
  logic [DATA_MAX-1:0] sh;
  logic                nacc;
  logic                pacc;

  assign ndata    = nine_bit ? N_LONG : N_SHORT;
  assign stop_idx = ndata + {{(IW-1){1'b0}}, par_en} + I_ONE;
  assign halt     = bit_vld && (((idx == '0) && bit_val) || (idx == stop_idx));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx   <= '0;
      sh    <= '0;
      nacc  <= 1'b0;
      pacc  <= 1'b0;
      xfer  <= 1'b0;
      xdata <= '0;
      xerr  <= '0;
    end else begin
      xfer <= 1'b0;
      if (bit_vld) begin
        if (idx == '0) begin
          if (!bit_val) begin
            idx  <= I_ONE;
            nacc <= bit_noise;
            pacc <= par_odd;
            sh   <= '0;
          end
        end else if (idx == stop_idx) begin
          xfer        <= 1'b1;
          xdata       <= nine_bit ? sh : {1'b0, sh[DATA_MAX-1:1]};
          xerr.noise  <= nacc | bit_noise;
          xerr.parity <= par_en & pacc;
          xerr.frame  <= ~bit_val;
          idx         <= '0;
        end else if (idx <= ndata) begin
          sh   <= {bit_val, sh[DATA_MAX-1:1]};
          pacc <= pacc ^ bit_val;
          nacc <= nacc | bit_noise;
          idx  <= idx + I_ONE;
        end else begin
          pacc <= pacc ^ bit_val;
          nacc <= nacc | bit_noise;
          idx  <= idx + I_ONE;
        end
      end
    end
  end

  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer) else $error("transfer lasted more than one cycle"); // R8

  AST_NO_XFER_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !xfer) else $error("transfer while disabled"); // R1

endmodule

// File: rtl/sci_rx_hold.sv
module sci_rx_hold
  import sci_rx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xfer,
  input  logic [DATA_MAX-1:0] xdata,
  input  rx_err_t             xerr,
  input  logic                rd,
  output logic [DATA_MAX-1:0] data,
  output logic                rdy,
  output rx_err_t             err,
  output logic                ovr
);

  logic accept;

  assign accept = xfer && (!rdy || rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      rdy  <= 1'b0;
      err  <= '0;
      ovr  <= 1'b0;
    end else begin
      if (accept) begin
        data <= xdata;
        err  <= xerr;
        rdy  <= 1'b1;
      end else if (rd) begin
        err  <= '0;
        rdy  <= 1'b0;
      end
      if (xfer && rdy && !rd) ovr <= 1'b1;
      else if (rd)            ovr <= 1'b0;
    end
  end

  AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (xfer && rdy && !rd) |=> ($stable(data) && ovr && rdy)) else $error("unread data overwritten"); // R11

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd && !xfer) |=> (!rdy && !ovr && err == '0)) else $error("read did not clear"); // R10

  AST_FLAGS_AT_XFER: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !rd) |=> ($stable(err) && $stable(data))) else $error("flags moved without transfer"); // R9

  AST_RDY_ON_XFER: assert property (@(posedge clk) disable iff (rst)
    (xfer && (!rdy || rd)) |=> (rdy && data == $past(xdata))) else $error("transfer did not load"); // R8

endmodule

// File: rtl/sci_rx_core.sv
module sci_rx_core
  import sci_rx_pkg::*;
#(
  parameter int DATA_MAX   = 9,
  parameter int OVS        = 16,
  parameter int SMP_FIRST  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_en,
  input  logic                tick,
  input  logic                rxd,
  input  logic                nine_bit,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                rd,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rdy,
  output logic                noise_flag,
  output logic                parity_flag,
  output logic                frame_flag,
  output logic                overrun
);

  logic                rxd_s;
  logic                bit_vld;
  logic                bit_val;
  logic                bit_noise;
  logic                halt;
  logic                xfer;
  logic [DATA_MAX-1:0] xdata;
  rx_err_t             xerr;
  rx_err_t             err;

  sci_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (rxd_s)
  );

  sci_rx_bitproc #(.OVS(OVS), .SMP_FIRST(SMP_FIRST)) i_bitproc (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .tick      (tick),
    .rxd       (rxd_s),
    .halt      (halt),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .bit_noise (bit_noise)
  );

  sci_rx_frame #(.DATA_MAX(DATA_MAX)) i_frame (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .nine_bit  (nine_bit),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .bit_noise (bit_noise),
    .halt      (halt),
    .xfer      (xfer),
    .xdata     (xdata),
    .xerr      (xerr)
  );

  sci_rx_hold #(.DATA_MAX(DATA_MAX)) i_hold (
    .clk   (clk),
    .rst   (rst),
    .xfer  (xfer),
    .xdata (xdata),
    .xerr  (xerr),
    .rd    (rd),
    .data  (rx_data),
    .rdy   (rdy),
    .err   (err),
    .ovr   (overrun)
  );

  assign noise_flag  = err.noise;
  assign parity_flag = err.parity;
  assign frame_flag  = err.frame;

endmodule

// File: tb/test_sci_rx_core.sv
module test_sci_rx_core;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, rx_en, tick, rxd, nine_bit, par_en, par_odd;
  logic       rd_mon, rd_man, rd;
  logic [8:0] rx_data;
  logic       rdy, noise_flag, parity_flag, frame_flag, overrun;

  assign rd = rd_mon | rd_man;

  sci_rx_core i_sci_rx_core (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tick(tick), .rxd(rxd),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd), .rd(rd),
    .rx_data(rx_data), .rdy(rdy), .noise_flag(noise_flag),
    .parity_flag(parity_flag), .frame_flag(frame_flag), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit mon_on = 0;

  typedef struct {
    logic [8:0] d;
    logic       nf, pf, fe;
  } exp_t;
  exp_t q[$];

  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) wait_tick();
  endtask

  // glitch inverts the line for exactly the second sample tick
  task automatic send_bit(logic v, bit glitch);
    rxd = v;
    if (glitch) begin
      ticks(8); rxd = ~v; ticks(1); rxd = v; ticks(7);
    end else ticks(16);
  endtask

  task automatic send_frame(logic [8:0] d, int glitch_at, bit bad_par,
                            logic stop_v, bit peek, bit expect_it);
    int   nd;
    logic p;
    exp_t e;
    nd = nine_bit ? 9 : 8;
    p  = par_odd;
    for (int i = 0; i < nd; i++) p ^= d[i];
    if (bad_par) p = ~p;
    e.d  = nine_bit ? d : {1'b0, d[7:0]};
    e.nf = (glitch_at >= 0);
    e.pf = bad_par && par_en;
    e.fe = ~stop_v;
    if (expect_it) q.push_back(e);
    rxd = 1'b1; ticks(2);
    send_bit(1'b0, glitch_at == 0);
    for (int i = 0; i < nd; i++) send_bit(d[i], glitch_at == i + 1);
    if (par_en) send_bit(p, glitch_at == nd + 1);
    if (peek) begin
      rxd = stop_v; ticks(4);
      chk(!rdy && !parity_flag && !noise_flag && !frame_flag, "R9",
          "flags before transfer", {rdy, noise_flag, parity_flag, frame_flag}, 0);
      ticks(12);
    end else send_bit(stop_v, glitch_at == nd + par_en + 1);
    if (!stop_v) begin rxd = 1'b1; ticks(16); end
  endtask

  task automatic man_read();
    @(negedge clk); rd_man = 1'b1; @(negedge clk); rd_man = 1'b0; @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    rd_mon = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on && rdy) begin
        if (q.size() == 0) chk(0, "R8", "unexpected frame", rx_data, 0);
        else begin
          e = q.pop_front();
          chk(rx_data == e.d, "R5", "data", rx_data, e.d);
          chk(noise_flag == e.nf, "R4", "noise flag", noise_flag, e.nf);
          chk(parity_flag == e.pf, "R6", "parity flag", parity_flag, e.pf);
          chk(frame_flag == e.fe, "R7", "framing flag", frame_flag, e.fe);
        end
        rd_mon = 1'b1;
        @(negedge clk);
        rd_mon = 1'b0;
      end
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst = 1'b1; rx_en = 1'b1; rxd = 1'b1; rd_man = 1'b0;
    nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rdy && !noise_flag && !parity_flag && !frame_flag && !overrun && rx_data == 0,
        "R8", "reset state", {rdy, noise_flag, parity_flag, frame_flag, overrun}, 0);

    mon_on = 1;
    // R5: 8-bit frames
    send_frame(9'h0A5, -1, 0, 1, 0, 1);
    send_frame(9'h000, -1, 0, 1, 0, 1);
    send_frame(9'h0FF, -1, 0, 1, 0, 1);
    send_frame(9'h13C, -1, 0, 1, 0, 1);
    // R5: 9-bit frames
    nine_bit = 1'b1;
    send_frame(9'h1A5, -1, 0, 1, 0, 1);
    send_frame(9'h0FF, -1, 0, 1, 0, 1);
    nine_bit = 1'b0;
    // R6: even and odd parity, good and bad; R9 peek on a bad one
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(9'h05A, -1, 0, 1, 0, 1);
    send_frame(9'h05B, -1, 1, 1, 1, 1);
    par_odd = 1'b1;
    send_frame(9'h007, -1, 0, 1, 0, 1);
    send_frame(9'h007, -1, 1, 1, 0, 1);
    par_en = 1'b0; par_odd = 1'b0;
    // R3 R4: glitch on a data bit, on the start bit, on the stop bit
    send_frame(9'h096, 3, 0, 1, 0, 1);
    send_frame(9'h0C3, 0, 0, 1, 0, 1);
    send_frame(9'h021, 9, 0, 1, 0, 1);
    // R7: stop bit low
    send_frame(9'h055, -1, 0, 0, 0, 1);
    ticks(4);
    chk(q.size() == 0, "R8", "frames left in scoreboard", q.size(), 0);

    // R2: short low pulse is not a start bit
    rxd = 1'b0; ticks(3); rxd = 1'b1; ticks(40);
    chk(!rdy, "R2", "false start produced frame", rdy, 0);
    send_frame(9'h081, -1, 0, 1, 0, 1);
    ticks(4);
    chk(q.size() == 0, "R2", "frame after false start", q.size(), 0);

    // R1: disabled receiver ignores a whole frame
    rx_en = 1'b0;
    send_frame(9'h0AA, -1, 0, 1, 0, 0);
    ticks(4);
    chk(!rdy, "R1", "frame while disabled", rdy, 0);
    rx_en = 1'b1;
    send_frame(9'h042, -1, 0, 1, 0, 1);
    // R1: disable mid-frame discards the partial frame
    rxd = 1'b1; ticks(2);
    send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b0, 0);
    rx_en = 1'b0; ticks(2); rx_en = 1'b1;
    rxd = 1'b1; ticks(120);
    chk(!rdy, "R1", "partial frame after disable", rdy, 0);
    send_frame(9'h0E7, -1, 0, 1, 0, 1);
    ticks(4);
    chk(q.size() == 0, "R1", "frames left after enable", q.size(), 0);

    // R11: overrun keeps the older word
    mon_on = 0;
    send_frame(9'h011, -1, 0, 1, 0, 0);
    ticks(2);
    chk(rdy && rx_data == 9'h011 && !overrun, "R8", "first held word", rx_data, 9'h011);
    par_en = 1'b1;
    send_frame(9'h022, -1, 1, 1, 0, 0);
    ticks(2);
    chk(overrun == 1'b1, "R11", "overrun flag", overrun, 1);
    chk(rx_data == 9'h011, "R11", "older word kept", rx_data, 9'h011);
    chk(!parity_flag, "R11", "older flags kept", parity_flag, 0);
    man_read();
    chk(!rdy && !overrun, "R10", "read clears ready and overrun", {rdy, overrun}, 0);
    // R10: read clears error flags
    send_frame(9'h033, 2, 1, 0, 0, 0);
    ticks(2);
    chk(rdy && parity_flag && noise_flag && frame_flag, "R10", "flags set before read",
        {rdy, noise_flag, parity_flag, frame_flag}, 4'hF);
    man_read();
    chk(!rdy && !parity_flag && !noise_flag && !frame_flag, "R10", "flags after read",
        {rdy, noise_flag, parity_flag, frame_flag}, 0);
    par_en = 1'b0;
    ticks(4);
    finish_up();
  end

endmodule